// File: doc/BRIEF.md
# Multi-Peer Shared-Region Access Guard

This block sits in front of one shared memory region that several peers reach through a common request path. Each request carries a peer number, a byte offset, a direction and a 32-bit word. The guard works out which section of the region the offset falls in and checks whether that peer may perform that access there. It then either forwards the access to a small behavioural RAM or turns it away. A turned-away access gives a one-cycle error pulse that names the peer, and a read that is turned away returns zero.

The region is made of contiguous sections laid out upward from offset zero. The first is a peer-status table with one 32-bit word per peer. Next comes a common section that every peer may read and write. Last come the per-peer output sections, one for each peer in peer order and all the same size. Peers may only read the status table. A separate privileged port, used by the device itself, writes a peer's status word. Three section sizes arrive on configuration inputs. They are sampled once, when reset is released, and checked for page alignment and for fit. A good configuration makes the guard clear the status table and then open for traffic. A bad one parks it in a fault state.

Guard states: CHECK samples and validates the sizes. CLEAR writes zero into status words 0 to N-1, one per cycle. RUN serves traffic. FAULT is entered on a bad configuration and held until reset. Transitions: CHECK to CLEAR when the sizes are valid, CHECK to FAULT when they are not, and CLEAR to RUN after the last status word is cleared.

Top module: `shmem_access_guard`

## Requirements
- R1: With S, C and O the latched status, common and output section sizes in bytes, the status table covers offsets [0, S), the common section covers [S, S+C), and output section k covers [S+C+k*O, S+C+(k+1)*O) for k = 0 to N_PEERS-1. A section of size zero owns no offsets.
- R2: Any valid peer may read the status table. Every peer write to it is rejected and leaves memory unchanged.
- R3: Every valid peer may read and write the common section. Its size may be zero.
- R4: Output section k accepts writes only from peer k. Any valid peer may read any output section.
- R5: Three kinds of request are rejected: an offset at or beyond S+C+N_PEERS*O, an offset whose two low bits are not zero, and a peer number of N_PEERS or more.
- R6: A rejected request does not write memory. In the next cycle it gives rsp_valid together with a one-cycle rsp_err, rsp_err_peer equal to the requesting peer, and rsp_rdata equal to zero.
- R7: An accepted request gives rsp_valid with rsp_err low in the next cycle. An accepted read returns the word last stored at that offset. An accepted write stores the word.
- R8: While guard_ready is high, a privileged write with st_peer = k < N_PEERS stores st_value at byte offset 4*k (status word k). A privileged write naming a peer of N_PEERS or more, or made while guard_ready is low, changes nothing.
- R9: After each reset release, guard_ready rises N_PEERS+1 cycles later, and all N_PEERS status words then read as zero.
- R10: When reset is released, the configuration is faulty if any size is not a multiple of PAGE_BYTES, if S is zero or smaller than 4*N_PEERS, or if S+C+N_PEERS*O exceeds 4*MEM_WORDS. A faulty configuration raises cfg_error one cycle later and holds it, guard_ready never rises, and every request is rejected.
- R11: Section sizes are sampled only in the first cycle after reset release. Later changes on the configuration inputs do not move the section boundaries.
- R12: A request made while guard_ready is low is rejected as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_state_bytes | input | AW | Status table size in bytes |
| cfg_common_bytes | input | AW | Common section size in bytes |
| cfg_out_bytes | input | AW | Size of each per-peer output section in bytes |
| req_valid | input | 1 | Peer request present this cycle |
| req_peer | input | PEER_W | Requesting peer number |
| req_offset | input | AW | Byte offset into the region |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write word |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_rdata | output | 32 | Read word, zero unless an accepted read |
| rsp_err | output | 1 | One-cycle rejection pulse |
| rsp_err_peer | output | PEER_W | Peer whose request was rejected |
| st_wr | input | 1 | Privileged status-word write |
| st_peer | input | PEER_W | Peer whose status word is written |
| st_value | input | 32 | Status value |
| guard_ready | output | 1 | Guard is serving traffic |
| cfg_error | output | 1 | Latched configuration fault |

## Verification
Every peer response, and every error pulse, appears exactly one cycle after the clock edge that takes the request. The bench therefore drives each request on a falling edge and reads the response on the next falling edge. It also checks that rsp_err is low again one cycle later. After reset release, cfg_error is due one cycle later and guard_ready N_PEERS+1 cycles later. The bench counts falling edges from the release and compares both flags at each count. A privileged write takes effect at the edge that takes it, so a peer read started on the following falling edge already sees the new value.

// File: rtl/shmem_guard_pkg.sv
package shmem_guard_pkg;

    typedef enum logic [1:0] {
        G_CHECK = 2'd0,
        G_CLEAR = 2'd1,
        G_RUN   = 2'd2,
        G_FAULT = 2'd3
    } guard_state_e;

    typedef enum logic [1:0] {
        SEC_STATE  = 2'd0,
        SEC_COMMON = 2'd1,
        SEC_OUTPUT = 2'd2,
        SEC_NONE   = 2'd3
    } sec_kind_e;

    localparam int unsigned WORD_BYTES = 4;

endpackage

// File: rtl/sg_section_map.sv
module sg_section_map
    import shmem_guard_pkg::*;
#(
    parameter int N_PEERS = 4,
    parameter int AW      = 16,
    parameter int PEER_W  = 3,
    parameter int EW      = 20
) (
    input  logic [AW-1:0]     st_bytes,
    input  logic [AW-1:0]     cm_bytes,
    input  logic [AW-1:0]     out_bytes,
    input  logic [AW-1:0]     offset,
    input  logic [PEER_W-1:0] peer,
    input  logic              write,
    output sec_kind_e         kind,
    output logic              allow
);

    logic [EW-1:0]      off_e;
    logic [EW-1:0]      cm_base;
    logic [EW-1:0]      out_base;
    logic [EW-1:0]      region_end;
    logic [N_PEERS-1:0] out_hit;
    logic               own_hit;
    logic               peer_ok;
    logic               aligned;
    logic               perm;

    assign off_e      = EW'(offset);
    assign cm_base    = EW'(st_bytes);
    assign out_base   = cm_base + EW'(cm_bytes);
    assign region_end = out_base + EW'(N_PEERS) * EW'(out_bytes);

    // one window comparator per output section
    for (genvar k = 0; k < N_PEERS; k++) begin : g_out_win
        logic [EW-1:0] lo;
        logic [EW-1:0] hi;
        assign lo         = out_base + EW'(k) * EW'(out_bytes);
        assign hi         = lo + EW'(out_bytes);
        assign out_hit[k] = (off_e >= lo) && (off_e < hi);
    end

    always_comb begin
        own_hit = 1'b0;
        for (int i = 0; i < N_PEERS; i++) begin
            if (out_hit[i] && (PEER_W'(i) == peer)) own_hit = 1'b1;
        end
    end

    always_comb begin
        if (off_e < cm_base)       kind = SEC_STATE;
        else if (off_e < out_base) kind = SEC_COMMON;
        else if (|out_hit)         kind = SEC_OUTPUT;
        else                       kind = SEC_NONE;
    end

    assign peer_ok = (peer < PEER_W'(N_PEERS));
    assign aligned = (offset[1:0] == 2'b00);

    always_comb begin
        perm = 1'b0;
        unique case (kind)
            SEC_STATE:  perm = !write;
            SEC_COMMON: perm = 1'b1;
            SEC_OUTPUT: perm = !write || own_hit;
            SEC_NONE:   perm = 1'b0;
            default:    perm = 1'b0;
        endcase
        allow = perm && peer_ok && aligned;
    end

    // R1: output windows never overlap and all lie below the region end
    always_comb begin
        assert_out_windows_disjoint_R1: assert ($onehot0(out_hit));
        if (|out_hit) begin
            assert_out_below_end_R5: assert (off_e < region_end);
        end
    end

endmodule

// File: rtl/sg_cfg_check.sv
module sg_cfg_check #(
    parameter int N_PEERS    = 4,
    parameter int AW         = 16,
    parameter int EW         = 20,
    parameter int PAGE_BYTES = 4096,
    parameter int MEM_WORDS  = 2048
) (
    input  logic [AW-1:0] st_bytes,
    input  logic [AW-1:0] cm_bytes,
    input  logic [AW-1:0] out_bytes,
    output logic          bad
);

    localparam logic [AW-1:0] PAGE_MASK = AW'(PAGE_BYTES - 1);
    localparam logic [EW-1:0] CAPACITY  = EW'(MEM_WORDS * 4);
    localparam logic [EW-1:0] ST_MIN    = EW'(N_PEERS * 4);

    logic [EW-1:0] total;
    logic          misaligned;
    logic          too_small;
    logic          too_big;

    assign total      = EW'(st_bytes) + EW'(cm_bytes) + EW'(N_PEERS) * EW'(out_bytes);
    assign misaligned = (|(st_bytes & PAGE_MASK)) || (|(cm_bytes & PAGE_MASK))
                     || (|(out_bytes & PAGE_MASK));
    assign too_small  = (st_bytes == '0) || (EW'(st_bytes) < ST_MIN);
    assign too_big    = (total > CAPACITY);
    assign bad        = misaligned || too_small || too_big;

endmodule

// File: rtl/sg_dual_ram.sv
module sg_dual_ram #(
    parameter int WORDS = 2048,
    parameter int IW    = 11
) (
    input  logic          clk,
    input  logic          a_en,
    input  logic          a_we,
    input  logic [IW-1:0] a_idx,
    input  logic [31:0]   a_wdata,
    output logic [31:0]   a_rdata,
    input  logic          b_we,
    input  logic [IW-1:0] b_idx,
    input  logic [31:0]   b_wdata
);

    logic [31:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (a_en && a_we) mem[a_idx] <= a_wdata;
        if (b_we)         mem[b_idx] <= b_wdata;
        if (a_en && !a_we) a_rdata <= mem[a_idx];
    end

endmodule

// File: rtl/shmem_access_guard.sv
module shmem_access_guard
    import shmem_guard_pkg::*;
#(
    parameter int N_PEERS    = 4,
    parameter int AW         = 16,
    parameter int PAGE_BYTES = 4096,
    parameter int MEM_WORDS  = 2048,
    parameter int PEER_W     = $clog2(N_PEERS) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     cfg_state_bytes,
    input  logic [AW-1:0]     cfg_common_bytes,
    input  logic [AW-1:0]     cfg_out_bytes,
    input  logic              req_valid,
    input  logic [PEER_W-1:0] req_peer,
    input  logic [AW-1:0]     req_offset,
    input  logic              req_write,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err,
    output logic [PEER_W-1:0] rsp_err_peer,
    input  logic              st_wr,
    input  logic [PEER_W-1:0] st_peer,
    input  logic [31:0]       st_value,
    output logic              guard_ready,
    output logic              cfg_error
);

    localparam int IW = $clog2(MEM_WORDS);
    localparam int EW = AW + PEER_W + 1;

    guard_state_e      gs_q, gs_d;
    logic [PEER_W-1:0] clr_idx_q;
    logic [AW-1:0]     st_q, cm_q, out_q;
    logic              cfg_bad;
    logic              clr_we;

    sec_kind_e         dec_kind;
    logic              dec_allow;
    logic              grant;
    logic              priv_ok;

    logic              b_we;
    logic [IW-1:0]     b_idx;
    logic [31:0]       b_wdata;
    logic [31:0]       ram_q;

    logic              rsp_v_q, rej_q, rd_q;
    logic [PEER_W-1:0] peer_q;

    sg_cfg_check #(
        .N_PEERS(N_PEERS), .AW(AW), .EW(EW),
        .PAGE_BYTES(PAGE_BYTES), .MEM_WORDS(MEM_WORDS)
    ) u_cfg (
        .st_bytes (cfg_state_bytes),
        .cm_bytes (cfg_common_bytes),
        .out_bytes(cfg_out_bytes),
        .bad      (cfg_bad)
    );

    sg_section_map #(
        .N_PEERS(N_PEERS), .AW(AW), .PEER_W(PEER_W), .EW(EW)
    ) u_map (
        .st_bytes (st_q),
        .cm_bytes (cm_q),
        .out_bytes(out_q),
        .offset   (req_offset),
        .peer     (req_peer),
        .write    (req_write),
        .kind     (dec_kind),
        .allow    (dec_allow)
    );

    // state register, latched configuration and clear counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gs_q      <= G_CHECK;
            clr_idx_q <= '0;
            st_q      <= '0;
            cm_q      <= '0;
            out_q     <= '0;
        end else begin
            gs_q <= gs_d;
            if (gs_q == G_CHECK) begin
                st_q  <= cfg_state_bytes;
                cm_q  <= cfg_common_bytes;
                out_q <= cfg_out_bytes;
            end
            if (clr_we) clr_idx_q <= clr_idx_q + 1'b1;
        end
    end

    // next state and state outputs
    always_comb begin
        gs_d        = gs_q;
        clr_we      = 1'b0;
        guard_ready = 1'b0;
        cfg_error   = 1'b0;
        unique case (gs_q)
            G_CHECK: gs_d = cfg_bad ? G_FAULT : G_CLEAR;
            G_CLEAR: begin
                clr_we = 1'b1;
                if (clr_idx_q == PEER_W'(N_PEERS - 1)) gs_d = G_RUN;
            end
            G_RUN:   guard_ready = 1'b1;
            G_FAULT: cfg_error   = 1'b1;
            default: gs_d = G_FAULT;
        endcase
    end

    // peer path
    assign grant = req_valid && guard_ready && dec_allow;

    // privileged and clear path share the second RAM port
    assign priv_ok = st_wr && guard_ready && (st_peer < PEER_W'(N_PEERS));
    assign b_we    = clr_we || priv_ok;
    assign b_idx   = clr_we ? IW'(clr_idx_q) : IW'(st_peer);
    assign b_wdata = clr_we ? 32'h0 : st_value;

    sg_dual_ram #(.WORDS(MEM_WORDS), .IW(IW)) u_ram (
        .clk    (clk),
        .a_en   (grant),
        .a_we   (req_write),
        .a_idx  (req_offset[IW+1:2]),
        .a_wdata(req_wdata),
        .a_rdata(ram_q),
        .b_we   (b_we),
        .b_idx  (b_idx),
        .b_wdata(b_wdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_v_q <= 1'b0;
            rej_q   <= 1'b0;
            rd_q    <= 1'b0;
            peer_q  <= '0;
        end else begin
            rsp_v_q <= req_valid;
            rej_q   <= req_valid && !grant;
            rd_q    <= grant && !req_write;
            peer_q  <= req_peer;
        end
    end

    assign rsp_valid    = rsp_v_q;
    assign rsp_err      = rej_q;
    assign rsp_err_peer = rej_q ? peer_q : '0;
    assign rsp_rdata    = rd_q ? ram_q : 32'h0;

    assert_state_not_peer_written_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && req_write) |-> (dec_kind != SEC_STATE));

    assert_reject_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !grant) |=> (rsp_err && rsp_rdata == 32'h0 && rsp_err_peer == $past(req_peer)));

    assert_accept_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && grant) |=> (rsp_valid && !rsp_err));

    assert_idle_no_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_err));

    assert_priv_only_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (b_we && !clr_we) |-> guard_ready);

    assert_ready_after_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(guard_ready) |-> ($past(gs_q) == G_CLEAR));

    assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_error |=> (cfg_error && !guard_ready));

    assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        guard_ready |=> ($stable(st_q) && $stable(cm_q) && $stable(out_q)));

    assert_notready_reject_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !guard_ready) |=> rsp_err);

endmodule

// File: tb/shmem_access_guard_tb_top.sv
module shmem_access_guard_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 4;
    localparam int AW         = 10;
    localparam int PAGE       = 16;
    localparam int MW         = 256;
    localparam int PW         = 3;
    localparam int WD_LIMIT   = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] cfg_state_bytes = '0, cfg_common_bytes = '0, cfg_out_bytes = '0;
    logic          req_valid = 1'b0;
    logic [PW-1:0] req_peer = '0;
    logic [AW-1:0] req_offset = '0;
    logic          req_write = 1'b0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid, rsp_err, guard_ready, cfg_error;
    logic [31:0]   rsp_rdata;
    logic [PW-1:0] rsp_err_peer;
    logic          st_wr = 1'b0;
    logic [PW-1:0] st_peer = '0;
    logic [31:0]   st_value = '0;

    int n_total = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int S, C, O;
    bit dut_up;
    logic [31:0] shadow [MW];

    always #(CLK_PERIOD/2) clk = ~clk;

    shmem_access_guard #(
        .N_PEERS(N), .AW(AW), .PAGE_BYTES(PAGE), .MEM_WORDS(MW), .PEER_W(PW)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_state_bytes(cfg_state_bytes), .cfg_common_bytes(cfg_common_bytes),
        .cfg_out_bytes(cfg_out_bytes),
        .req_valid(req_valid), .req_peer(req_peer), .req_offset(req_offset),
        .req_write(req_write), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .rsp_err_peer(rsp_err_peer),
        .st_wr(st_wr), .st_peer(st_peer), .st_value(st_value),
        .guard_ready(guard_ready), .cfg_error(cfg_error)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == WD_LIMIT) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // -1 none, 0 status table, 1 common, 2+k output section k
    function automatic int section_of(input int off);
        if (off < S)           return 0;
        if (off < S + C)       return 1;
        if (off < S + C + N*O) return 2 + (off - S - C) / O;
        return -1;
    endfunction

    function automatic bit may_access(input int p, input int off, input bit we);
        int sec;
        if (!dut_up || p >= N || (off % 4) != 0) return 1'b0;
        sec = section_of(off);
        if (sec < 0)  return 1'b0;
        if (sec == 0) return !we;
        if (sec == 1) return 1'b1;
        return !we || (sec - 2 == p);
    endfunction

    function automatic string tag_of(input int p, input int off);
        int sec;
        if (!dut_up) return "R12/R10 not ready";
        if (p >= N || (off % 4) != 0) return "R5 bad peer/align";
        sec = section_of(off);
        if (sec < 0)  return "R5 out of range";
        if (sec == 0) return "R2 status table";
        if (sec == 1) return "R3 common";
        return "R4 output";
    endfunction

    // called at a falling edge; returns at the next one
    task automatic access(input int p, input int off, input bit we, input logic [31:0] wd, input string tag_in);
        bit    ok;
        string tag;
        ok  = may_access(p, off, we);
        tag = (tag_in == "") ? tag_of(p, off) : tag_in;
        req_valid  = 1'b1;
        req_peer   = PW'(p);
        req_offset = AW'(off);
        req_write  = we;
        req_wdata  = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid === 1'b1, {tag, " R7 rsp_valid"}, 32'(rsp_valid), 32'd1);
        if (ok) begin
            check(rsp_err === 1'b0, {tag, " R7 accepted"}, 32'(rsp_err), 32'd0);
            if (we) shadow[off/4] = wd;
            else check(rsp_rdata === shadow[off/4], {tag, " R7 read data"}, rsp_rdata, shadow[off/4]);
        end else begin
            check(rsp_err === 1'b1 && rsp_err_peer === PW'(p), {tag, " R6 reject peer"},
                  {rsp_err, 28'h0, rsp_err_peer}, {1'b1, 28'h0, PW'(p)});
            check(rsp_rdata === 32'h0, {tag, " R6 reject data"}, rsp_rdata, 32'h0);
        end
    endtask

    task automatic priv_write(input int p, input logic [31:0] v);
        st_wr    = 1'b1;
        st_peer  = PW'(p);
        st_value = v;
        @(negedge clk);
        st_wr = 1'b0;
        if (dut_up && p < N) shadow[p] = v;
    endtask

    // reset, then R12 probe and ready/fault timing
    task automatic start(input int s, input int c, input int o, input bit exp_bad);
        cfg_state_bytes  = AW'(s);
        cfg_common_bytes = AW'(c);
        cfg_out_bytes    = AW'(o);
        S = s; C = c; O = o;
        dut_up = 1'b0;
        rst_n  = 1'b0;
        repeat (3) @(negedge clk);
        check(guard_ready === 1'b0 && rsp_valid === 1'b0 && cfg_error === 1'b0, "R9 reset state",
              {guard_ready, rsp_valid, cfg_error}, 32'd0);
        rst_n = 1'b1;
        access(1, S, 1'b0, 32'h0, "R12 request during check");
        check(cfg_error === exp_bad, "R10 cfg_error after one cycle", 32'(cfg_error), 32'(exp_bad));
        for (int i = 2; i <= N + 3; i++) begin
            @(negedge clk);
            check(guard_ready === (!exp_bad && i >= N + 1), "R9 ready timing",
                  32'(guard_ready), 32'(!exp_bad && i >= N + 1));
        end
        if (!exp_bad) begin
            dut_up = 1'b1;
            for (int k = 0; k < N; k++) shadow[k] = 32'h0;
        end
    endtask

    task automatic sweep();
        int last;
        last = S + C + N*O + 8;
        for (int p = 0; p <= N; p++) begin
            for (int off = 0; off <= last; off += 4)
                access(p, off, 1'b1, 32'hA000_0000 | (p << 16) | off, "");
            access(p, S + C + 1, 1'b1, 32'hBAD0_0000, "R5 misaligned write");
            access(p, 2, 1'b0, 32'h0, "R5 misaligned read");
            @(negedge clk);
            check(rsp_err === 1'b0 && rsp_valid === 1'b0, "R6 pulse lasts one cycle", 32'(rsp_err), 32'd0);
        end
        for (int p = 0; p <= N; p++)
            for (int off = 0; off <= last; off += 4)
                access(p, off, 1'b0, 32'h0, "");
    endtask

    initial begin
        for (int i = 0; i < MW; i++) shadow[i] = 32'h0;
        @(negedge clk);

        // configuration 1: S=16, C=32, O=16, end 112
        start(16, 32, 16, 1'b0);
        for (int k = 0; k < N; k++) access(2, 4*k, 1'b0, 32'h0, "R9 status cleared");
        sweep();
        for (int k = 0; k < N; k++) priv_write(k, 32'h5EED_0000 + k);
        priv_write(N, 32'hDEAD_BEEF);
        for (int k = 0; k <= N; k++) access(3, 4*k, 1'b0, 32'h0, "R8 privileged write");

        // configuration 2: S=16, no common section, O=32, end 144
        start(16, 0, 32, 1'b0);
        for (int k = 0; k < N; k++) access(0, 4*k, 1'b0, 32'h0, "R9 status cleared after reset");
        sweep();
        cfg_out_bytes = AW'(16);
        access(1, 140, 1'b0, 32'h0, "R11 frozen sizes read");
        access(3, 140, 1'b1, 32'h1234_5678, "R11 frozen sizes owner write");
        access(0, 140, 1'b0, 32'h0, "R11 frozen sizes readback");

        // configuration 3: status size not page aligned
        start(24, 32, 16, 1'b1);
        access(0, 32, 1'b0, 32'h0, "R10 fault rejects read");
        access(0, 32, 1'b1, 32'h1, "R10 fault rejects write");

        // configuration 4: region larger than memory
        start(16, 512, 128, 1'b1);
        access(1, 16, 1'b0, 32'h0, "R10 oversize rejects");

        // configuration 5: empty status table
        start(0, 32, 16, 1'b1);
        access(2, 0, 1'b0, 32'h0, "R10 zero status rejects");

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule